// File: doc/BRIEF.md
# Keyed watchdog enable sequencer

This block is the control half of a watchdog that sits beside a 64-bit counter. Software arms it by writing a control word. The word carries a 16-bit key in bits 31:16 and an enable flag in bit 14. Two fixed keys, written in a fixed order and each with the enable flag set, move the watchdog from inactive to pre-active and then to active. Any other write during arming drops the sequence back to inactive and does nothing else.

Once the watchdog is active it cannot be turned off by software. Writing the first key and then the second key services it: a one-cycle pulse tells the counter to restart. A write with an unrecognised key raises the reset request at once. So does a counter expiry. The request then stays high until the block's own reset is applied. Control writes count only while the timer-mode select equals the watchdog-mode encoding.

Top module: `wdt_key_seq`

## Requirements
- R1: After reset, state_o is 0 (inactive), rst_req_o is 0 and svc_o is 0. The state codes are 0 for inactive, 1 for pre-active and 2 for active.
- R2: A write with key 0xA5C6 in bits 31:16 and bit 14 set, made while the state is inactive, gives state 1 in the cycle after the write. Bits 15 and 13:0 have no effect.
- R3: A write with key 0xDA7E and bit 14 set, made while the state is pre-active, gives state 2 in the cycle after the write.
- R4: While the state is inactive or pre-active, a write with any other key, or with bit 14 clear, leaves the state at 0 in the following cycle and does not assert rst_req_o.
- R5: A write made while mode_i is not 2 changes neither the state, nor the reset request, nor the service pulse.
- R6: While the state is active, a write whose key is neither 0xA5C6 nor 0xDA7E asserts rst_req_o in the cycle after the write. Bit 14 does not matter.
- R7: While the state is active, a write of 0xA5C6 followed later by a write of 0xDA7E makes svc_o high for exactly the one cycle after the 0xDA7E write. A write of 0xDA7E with no 0xA5C6 before it produces no pulse.
- R8: While the state is active, expire_i high for one cycle asserts rst_req_o in the next cycle.
- R9: Once the state is active, no write, mode value or expiry moves it away from 2. Only rst_ni does.
- R10: Once asserted, rst_req_o stays high until rst_ni is applied.
- R11: expire_i has no effect while the state is inactive or pre-active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word: key in 31:16, enable in 14 |
| mode_i | input | 2 | Timer-mode select; 2 means watchdog mode |
| expire_i | input | 1 | Counter expiry flag |
| state_o | output | 2 | Watchdog state (0 inactive, 1 pre-active, 2 active) |
| rst_req_o | output | 1 | Sticky reset request |
| svc_o | output | 1 | One-cycle counter restart pulse |

## Verification
The hardest case to reach is the effect of one write in each of the three states. Reaching the active state takes a complete and correct arming sequence from a clean reset, and a fired request cannot be undone without a reset. The bench therefore resets the block and replays the arming prefix before every single trial. It sweeps a set of keys against both values of the enable flag and all four mode values, starting from each state. Service pulses are then checked in sequences that include an ignored write placed between the two keys.

// File: rtl/wdt_key_pkg.sv
package wdt_key_pkg;
  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_PRE   = 2'd1,
    WD_ARMED = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdt_wr_decode.sv
module wdt_wr_decode #(
  parameter int DATA_W    = 32,
  parameter int KEY_W     = 16,
  parameter int KEY_LSB   = 16,
  parameter int EN_POS    = 14,
  parameter int MODE_W    = 2,
  parameter logic [MODE_W-1:0] WDOG_MODE  = 2,
  parameter logic [KEY_W-1:0]  KEY_FIRST  = 16'hA5C6,
  parameter logic [KEY_W-1:0]  KEY_SECOND = 16'hDA7E
) (
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              valid_o,
  output logic              hit0_o,
  output logic              hit1_o,
  output logic              bad_o,
  output logic              en_o
);
  localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

  logic [KEY_W-1:0] key;
  assign key     = wr_data_i[KEY_MSB:KEY_LSB];
  assign valid_o = wr_en_i && (mode_i == WDOG_MODE);
  assign hit0_o  = (key == KEY_FIRST);
  assign hit1_o  = (key == KEY_SECOND);
  assign bad_o   = !hit0_o && !hit1_o;
  assign en_o    = wr_data_i[EN_POS];

  logic unused_bits;
  assign unused_bits = ^{wr_data_i[KEY_LSB-1:EN_POS+1], wr_data_i[EN_POS-1:0]};
endmodule

// File: rtl/wdt_arm_fsm.sv
module wdt_arm_fsm
  import wdt_key_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  logic      hit0_i,
  input  logic      hit1_i,
  input  logic      en_i,
  output wd_state_e state_o,
  output logic      armed_o
);
  wd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WD_IDLE:  if (valid_i) state_d = (hit0_i && en_i) ? WD_PRE : WD_IDLE;
      WD_PRE:   if (valid_i) state_d = (hit1_i && en_i) ? WD_ARMED : WD_IDLE;
      WD_ARMED: state_d = WD_ARMED;
      default:  state_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= WD_IDLE;
    else         state_q <= state_d;

  assign state_o = state_q;
  assign armed_o = (state_q == WD_ARMED);

  // R3
  idle_no_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == WD_IDLE |=> state_q != WD_ARMED);
  // R9
  armed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == WD_ARMED |=> state_q == WD_ARMED);
  // R5
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q));
  // R4
  pre_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WD_PRE && valid_i && !en_i) |=> state_q == WD_IDLE);
endmodule

// File: rtl/wdt_service.sv
module wdt_service (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic valid_i,
  input  logic hit0_i,
  input  logic hit1_i,
  output logic svc_o
);
  logic pend_q, svc_q;
  logic wr_armed;
  assign wr_armed = armed_i && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      svc_q <= wr_armed && hit1_i && pend_q;
      if (wr_armed) begin
        if (hit0_i)                pend_q <= 1'b1;
        else                       pend_q <= 1'b0;
      end
    end

  assign svc_o = svc_q;

  // R7
  svc_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_q |=> !svc_q);
  // R7
  svc_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_q |-> armed_i);
  // R7
  svc_needs_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |=> !svc_q);
endmodule

// File: rtl/wdt_fault_latch.sv
module wdt_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic valid_i,
  input  logic bad_i,
  input  logic expire_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) req_q <= 1'b0;
    else if (armed_i && ((valid_i && bad_i) || expire_i)) req_q <= 1'b1;

  assign req_o = req_q;

  // R10
  req_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> req_q);
  // R6
  bad_key_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && valid_i && bad_i) |=> req_q);
  // R8
  expire_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && expire_i) |=> req_q);
  // R11
  unarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i && !req_q) |=> !req_q);
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_key_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int KEY_W     = 16,
  parameter int KEY_LSB   = 16,
  parameter int EN_POS    = 14,
  parameter int MODE_W    = 2,
  parameter logic [MODE_W-1:0] WDOG_MODE  = 2,
  parameter logic [KEY_W-1:0]  KEY_FIRST  = 16'hA5C6,
  parameter logic [KEY_W-1:0]  KEY_SECOND = 16'hDA7E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              expire_i,
  output logic [1:0]        state_o,
  output logic              rst_req_o,
  output logic              svc_o
);
  logic valid, hit0, hit1, bad, en, armed;
  wd_state_e state;

  wdt_wr_decode #(
    .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB), .EN_POS(EN_POS),
    .MODE_W(MODE_W), .WDOG_MODE(WDOG_MODE),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_dec (
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .mode_i(mode_i),
    .valid_o(valid), .hit0_o(hit0), .hit1_o(hit1), .bad_o(bad), .en_o(en)
  );

  wdt_arm_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid),
    .hit0_i(hit0), .hit1_i(hit1), .en_i(en),
    .state_o(state), .armed_o(armed)
  );

  wdt_service u_svc (
    .clk_i(clk_i), .rst_ni(rst_ni), .armed_i(armed), .valid_i(valid),
    .hit0_i(hit0), .hit1_i(hit1), .svc_o(svc_o)
  );

  wdt_fault_latch u_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .armed_i(armed), .valid_i(valid),
    .bad_i(bad), .expire_i(expire_i), .req_o(rst_req_o)
  );

  assign state_o = state;

  // R5
  off_mode_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mode_i != WDOG_MODE && !expire_i) |=> ($stable(state_o) && !svc_o));
  // R4
  arming_no_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'd2 && !rst_req_o) |=> !rst_req_o);
endmodule

// File: tb/sim_wdt_key_seq.sv
module sim_wdt_key_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  mode = 2'd0;
  logic        expire = 1'b0;
  logic [1:0]  state;
  logic        req, svc;
  int checks = 0, failures = 0, cyc = 0;

  always #10 clk = ~clk;

  wdt_key_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .mode_i(mode), .expire_i(expire), .state_o(state),
    .rst_req_o(req), .svc_o(svc)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog timeout act=%0d exp<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req_tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req_tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; wr_en = 1'b0; expire = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic do_write(logic [15:0] key, logic en, logic [1:0] md);
    wr_en   = 1'b1;
    wr_data = {key, 1'b1, en, 14'h2B5A};
    mode    = md;
    @(negedge clk);
    wr_en = 1'b0;
    mode  = 2'd0;
  endtask

  task automatic goto_state(int s);
    do_reset();
    if (s >= 1) do_write(16'hA5C6, 1'b1, 2'd2);
    if (s >= 2) do_write(16'hDA7E, 1'b1, 2'd2);
  endtask

  function automatic logic [15:0] key_at(int i);
    case (i)
      0: return 16'hA5C6;
      1: return 16'hDA7E;
      2: return 16'h0000;
      3: return 16'hFFFF;
      4: return 16'hA5C7;
      default: return 16'h5A39;
    endcase
  endfunction

  initial begin
    do_reset();
    // R1
    chk("R1 state", state, 0);
    chk("R1 req", req, 0);
    chk("R1 svc", svc, 0);

    // one write from each state: all key, enable and mode combinations
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 6; k++)
        for (int e = 0; e < 2; e++)
          for (int m = 0; m < 4; m++) begin
            logic [15:0] key;
            int exp_s, exp_r;
            string tag;
            key = key_at(k);
            exp_s = s; exp_r = 0;
            if (m == 2) begin
              if (s == 0) exp_s = (k == 0 && e == 1) ? 1 : 0;
              else if (s == 1) exp_s = (k == 1 && e == 1) ? 2 : 0;
              else exp_r = (k >= 2) ? 1 : 0;
            end
            if (m != 2) tag = "R5";
            else if (s == 2) tag = (k >= 2) ? "R6" : "R9";
            else if (exp_s == 1) tag = "R2";
            else if (exp_s == 2) tag = "R3";
            else tag = "R4";
            goto_state(s);
            do_write(key, e[0], m[1:0]);
            chk({tag, " state"}, state, exp_s);
            chk({tag, " req"}, req, exp_r);
            chk({tag, " svc"}, svc, 0);
          end

    // R7 service sequence with an ignored write between the keys
    goto_state(2);
    do_write(16'hA5C6, 1'b0, 2'd2);
    chk("R7 no pulse after first", svc, 0);
    do_write(16'hDA7E, 1'b1, 2'd1);
    chk("R7 off-mode second", svc, 0);
    do_write(16'hDA7E, 1'b0, 2'd2);
    chk("R7 pulse", svc, 1);
    @(negedge clk);
    chk("R7 pulse width", svc, 0);
    do_write(16'hDA7E, 1'b1, 2'd2);
    chk("R7 second without first", svc, 0);
    chk("R7 req quiet", req, 0);
    chk("R9 still active", state, 2);

    // R11 expiry before arming
    goto_state(0);
    expire = 1'b1; @(negedge clk); expire = 1'b0;
    chk("R11 idle expire", req, 0);
    goto_state(1);
    expire = 1'b1; @(negedge clk); expire = 1'b0;
    chk("R11 pre expire req", req, 0);
    chk("R11 pre expire state", state, 1);

    // R8 expiry while active, R10 stickiness
    goto_state(2);
    expire = 1'b1; @(negedge clk); expire = 1'b0;
    chk("R8 expire fires", req, 1);
    do_write(16'hA5C6, 1'b1, 2'd2);
    do_write(16'hDA7E, 1'b1, 2'd2);
    repeat (5) @(negedge clk);
    chk("R10 sticky", req, 1);
    chk("R9 active after fire", state, 2);
    do_reset();
    chk("R10 cleared by reset", req, 0);
    chk("R9 reset returns idle", state, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule